// File: doc/BRIEF.md
# Three-word stack machine core

A small multi-cycle processor core that executes a fixed-format program from a word-addressed, single-port memory. Each instruction takes three consecutive words: an opcode, an address operand and a value operand. The core always reads all three words. It then runs one of seven operations: no-op, halt, self-reset, debug, load-immediate, push or pop. It keeps an instruction pointer that starts at word 0. It also keeps a stack pointer that starts at the last memory word and grows downward.

The core sits idle after reset until a start pulse. It then fetches and executes instructions until it halts. It halts on a halt opcode or on an illegal opcode, and an illegal opcode also raises a sticky error flag. A debug-enable input makes the debug opcode show its operands on a one-cycle strobe. With debug disabled, the debug opcode is a no-op. Memory reads return data one cycle after the address is presented, and a write takes effect at the clock edge that ends the cycle in which it is driven.

Top module: `stk3_core`

## Requirements
- R1: After rst_ni is released, halted_o and error_o are 0 and no memory access is made. IP is 0 and SP is DEPTH-1, so a first PUSH writes word DEPTH-1.
- R2: An instruction is fetched with three reads in consecutive cycles: the opcode at IP, the address operand at IP+1 and the value operand at IP+2. Each read returns its data one cycle later.
- R3: After any instruction other than halt or an illegal opcode, the next fetch starts at IP+3. A program of LDI, NOP, HLT at word 0 reads exactly words 0 to 8.
- R4: The opcode encoding is NOP=0, HLT=1, RST=2, DBG=3, LDI=4, PUSH=5, POP=6. NOP writes nothing.
- R5: LDI writes the value operand to memory at the low log2(DEPTH) bits of the address operand.
- R6: PUSH writes the value operand at SP and then decrements SP, modulo DEPTH.
- R7: POP increments SP modulo DEPTH, reads the word at the new SP and writes it to the address operand.
- R8: HLT sets halted_o. From then on no memory read or write is made until rst_ni.
- R9: DBG with dbg_en_i high gives a one-cycle dbg_valid_o pulse with dbg_op_o=3 and the address and value operands. With dbg_en_i low, DBG has no effect and gives no pulse.
- R10: Any opcode above 6 sets error_o and halted_o, and both stay set until rst_ni.
- R11: The RST opcode sets SP to DEPTH-1 and IP to 0. Execution then resumes at word 3.
- R12: In idle, the core makes no memory access until start_i is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Leave idle and begin fetching |
| dbg_en_i | input | 1 | Enables the debug strobe |
| mem_addr_o | output | log2(DEPTH) | Memory word address |
| mem_re_o | output | 1 | Memory read request, data one cycle later |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data |
| halted_o | output | 1 | Core has stopped fetching |
| error_o | output | 1 | Sticky illegal-opcode flag |
| dbg_valid_o | output | 1 | Debug operands valid this cycle |
| dbg_op_o | output | DATA_W | Opcode of the debug instruction |
| dbg_addr_o | output | DATA_W | Address operand of the debug instruction |
| dbg_val_o | output | DATA_W | Value operand of the debug instruction |

## Verification
The hardest case to reach from the ports is the self-reset opcode. The only way to see it restore SP is to run code after it. Because execution resumes at word 3, any reset instruction placed later in the program is fetched again and loops forever. The stimulus breaks the loop with a pop that changes the reset word into a push. On the first pass the pop reads a reset opcode that was pushed earlier. On the second pass SP has wrapped back to DEPTH-1, so the pop reads word 0 instead. The final push then lands at word 0, which shows both the restored SP and the modulo wrap.

// File: rtl/stk3_pkg.sv
package stk3_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FOP, ST_FAD, ST_FVL, ST_EXE, ST_PRD, ST_PWR, ST_HALT
  } state_e;

  localparam int unsigned OPC_NOP  = 0;
  localparam int unsigned OPC_HLT  = 1;
  localparam int unsigned OPC_RST  = 2;
  localparam int unsigned OPC_DBG  = 3;
  localparam int unsigned OPC_LDI  = 4;
  localparam int unsigned OPC_PUSH = 5;
  localparam int unsigned OPC_POP  = 6;
  localparam int unsigned INSN_LEN = 3;

  typedef struct packed {
    logic nop;
    logic hlt;
    logic rst;
    logic dbg;
    logic ldi;
    logic push;
    logic pop;
    logic bad;
  } dec_t;
endpackage

// File: rtl/stk3_decode.sv
module stk3_decode
  import stk3_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] op_i,
  output dec_t              dec_o
);
  always_comb begin
    dec_o = '0;
    if      (op_i == DATA_W'(OPC_NOP))  dec_o.nop  = 1'b1;
    else if (op_i == DATA_W'(OPC_HLT))  dec_o.hlt  = 1'b1;
    else if (op_i == DATA_W'(OPC_RST))  dec_o.rst  = 1'b1;
    else if (op_i == DATA_W'(OPC_DBG))  dec_o.dbg  = 1'b1;
    else if (op_i == DATA_W'(OPC_LDI))  dec_o.ldi  = 1'b1;
    else if (op_i == DATA_W'(OPC_PUSH)) dec_o.push = 1'b1;
    else if (op_i == DATA_W'(OPC_POP))  dec_o.pop  = 1'b1;
    else                                dec_o.bad  = 1'b1;
  end
endmodule

// File: rtl/stk3_ptrs.sv
module stk3_ptrs
  import stk3_pkg::*;
#(
  parameter  int DEPTH = 65536,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ip_adv_i,
  input  logic          core_rst_i,
  input  logic          sp_dec_i,
  input  logic          sp_inc_i,
  output logic [AW-1:0] ip_o,
  output logic [AW-1:0] sp_o
);
  localparam logic [AW-1:0] SP_TOP = AW'(DEPTH - 1);
  localparam logic [AW-1:0] STEP   = AW'(INSN_LEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ip_o <= '0;
      sp_o <= SP_TOP;
    end else begin
      // software reset: IP to 0, then the usual advance
      if (core_rst_i)    ip_o <= STEP;
      else if (ip_adv_i) ip_o <= ip_o + STEP;

      if (core_rst_i)    sp_o <= SP_TOP;
      else if (sp_dec_i) sp_o <= sp_o - 1'b1;
      else if (sp_inc_i) sp_o <= sp_o + 1'b1;
    end
  end
endmodule

// File: rtl/stk3_ctrl.sv
module stk3_ctrl
  import stk3_pkg::*;
#(
  parameter  int DATA_W = 16,
  parameter  int DEPTH  = 65536,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dbg_en_i,
  input  logic [AW-1:0]     ip_i,
  input  logic [AW-1:0]     sp_i,
  input  dec_t              dec_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output state_e            state_o,
  output logic [DATA_W-1:0] op_q_o,
  output logic [DATA_W-1:0] ad_q_o,
  output logic              ip_adv_o,
  output logic              core_rst_o,
  output logic              sp_dec_o,
  output logic              sp_inc_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              halted_o,
  output logic              error_o,
  output logic              dbg_valid_o
);
  state_e            state_q, state_d;
  logic [DATA_W-1:0] op_q, ad_q;
  logic              err_q;
  logic [AW-1:0]     tgt_addr;

  generate
    if (DATA_W >= AW) begin : g_trunc
      assign tgt_addr = ad_q[AW-1:0];
    end else begin : g_zext
      assign tgt_addr = {{(AW-DATA_W){1'b0}}, ad_q};
    end
  endgenerate

  always_comb begin
    state_d     = state_q;
    mem_addr_o  = ip_i;
    mem_re_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_wdata_o = mem_rdata_i;
    ip_adv_o    = 1'b0;
    core_rst_o  = 1'b0;
    sp_dec_o    = 1'b0;
    sp_inc_o    = 1'b0;
    dbg_valid_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_FOP;
      ST_FOP: begin
        mem_re_o = 1'b1;
        state_d  = ST_FAD;
      end
      ST_FAD: begin
        mem_addr_o = ip_i + AW'(1);
        mem_re_o   = 1'b1;
        state_d    = ST_FVL;
      end
      ST_FVL: begin
        mem_addr_o = ip_i + AW'(2);
        mem_re_o   = 1'b1;
        state_d    = ST_EXE;
      end
      ST_EXE: begin
        // value operand is on mem_rdata_i in this cycle
        state_d = ST_FOP;
        if (dec_i.hlt || dec_i.bad) begin
          state_d = ST_HALT;
        end else if (dec_i.pop) begin
          sp_inc_o = 1'b1;
          state_d  = ST_PRD;
        end else if (dec_i.rst) begin
          core_rst_o = 1'b1;
        end else begin
          ip_adv_o = 1'b1;
          if (dec_i.ldi) begin
            mem_we_o   = 1'b1;
            mem_addr_o = tgt_addr;
          end
          if (dec_i.push) begin
            mem_we_o   = 1'b1;
            mem_addr_o = sp_i;
            sp_dec_o   = 1'b1;
          end
          dbg_valid_o = dec_i.dbg && dbg_en_i;
        end
      end
      ST_PRD: begin
        mem_addr_o = sp_i;
        mem_re_o   = 1'b1;
        state_d    = ST_PWR;
      end
      ST_PWR: begin
        mem_we_o   = 1'b1;
        mem_addr_o = tgt_addr;
        ip_adv_o   = 1'b1;
        state_d    = ST_FOP;
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      ad_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_FAD) op_q <= mem_rdata_i;
      if (state_q == ST_FVL) ad_q <= mem_rdata_i;
      if (state_q == ST_EXE && dec_i.bad) err_q <= 1'b1;
    end
  end

  assign state_o  = state_q;
  assign op_q_o   = op_q;
  assign ad_q_o   = ad_q;
  assign halted_o = (state_q == ST_HALT);
  assign error_o  = err_q;
endmodule

// File: rtl/stk3_core.sv
module stk3_core
  import stk3_pkg::*;
#(
  parameter  int DATA_W = 16,
  parameter  int DEPTH  = 65536,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dbg_en_i,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              halted_o,
  output logic              error_o,
  output logic              dbg_valid_o,
  output logic [DATA_W-1:0] dbg_op_o,
  output logic [DATA_W-1:0] dbg_addr_o,
  output logic [DATA_W-1:0] dbg_val_o
);
  state_e            state;
  dec_t              dec;
  logic [DATA_W-1:0] op_q, ad_q;
  logic [AW-1:0]     ip, sp;
  logic              ip_adv, core_rst, sp_dec, sp_inc;

  stk3_decode #(.DATA_W(DATA_W)) u_dec (
    .op_i  (op_q),
    .dec_o (dec)
  );

  stk3_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ip_adv_i   (ip_adv),
    .core_rst_i (core_rst),
    .sp_dec_i   (sp_dec),
    .sp_inc_i   (sp_inc),
    .ip_o       (ip),
    .sp_o       (sp)
  );

  stk3_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .dbg_en_i    (dbg_en_i),
    .ip_i        (ip),
    .sp_i        (sp),
    .dec_i       (dec),
    .mem_rdata_i (mem_rdata_i),
    .state_o     (state),
    .op_q_o      (op_q),
    .ad_q_o      (ad_q),
    .ip_adv_o    (ip_adv),
    .core_rst_o  (core_rst),
    .sp_dec_o    (sp_dec),
    .sp_inc_o    (sp_inc),
    .mem_addr_o  (mem_addr_o),
    .mem_re_o    (mem_re_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .halted_o    (halted_o),
    .error_o     (error_o),
    .dbg_valid_o (dbg_valid_o)
  );

  assign dbg_op_o   = op_q;
  assign dbg_addr_o = ad_q;
  assign dbg_val_o  = mem_rdata_i;
endmodule

// File: rtl/stk3_core_chk.sv
module stk3_core_chk
  import stk3_pkg::*;
#(
  parameter  int DATA_W = 16,
  parameter  int DEPTH  = 65536,
  localparam int AW     = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dbg_en_i,
  input logic [AW-1:0]     mem_addr_o,
  input logic              mem_re_o,
  input logic              mem_we_o,
  input logic              halted_o,
  input logic              error_o,
  input logic              dbg_valid_o,
  input logic [DATA_W-1:0] dbg_op_o,
  input state_e            state,
  input dec_t              dec,
  input logic [AW-1:0]     ip,
  input logic [AW-1:0]     sp
);
  localparam logic [AW-1:0] SP_TOP = AW'(DEPTH - 1);

  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> (!mem_re_o && !mem_we_o));

  assert_ip_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_EXE && (dec.nop || dec.dbg || dec.ldi || dec.push))
    |=> (ip == $past(ip) + AW'(3)));

  assert_push_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_EXE && dec.push) |-> (mem_we_o && mem_addr_o == sp));

  assert_push_sp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_EXE && dec.push) |=> (sp == $past(sp) - AW'(1)));

  assert_pop_sp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_EXE && dec.pop) |=> (sp == $past(sp) + AW'(1) && mem_re_o && mem_addr_o == sp));

  assert_halt_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && !mem_re_o && !mem_we_o));

  assert_dbg_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_valid_o |-> (dbg_en_i && dbg_op_o == DATA_W'(OPC_DBG)));

  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> error_o);

  assert_err_halt_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> halted_o);

  assert_core_rst_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_EXE && dec.rst) |=> (ip == AW'(3) && sp == SP_TOP));
endmodule

bind stk3_core stk3_core_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dbg_en_i    (dbg_en_i),
  .mem_addr_o  (mem_addr_o),
  .mem_re_o    (mem_re_o),
  .mem_we_o    (mem_we_o),
  .halted_o    (halted_o),
  .error_o     (error_o),
  .dbg_valid_o (dbg_valid_o),
  .dbg_op_o    (dbg_op_o),
  .state       (state),
  .dec         (dec),
  .ip          (ip),
  .sp          (sp)
);

// File: tb/stk3_core_bench.sv
module stk3_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 16;
  localparam int DEP = 256;
  localparam int AW  = 8;
  localparam int NVEC = 8;

  // {op, addr operand, value operand, check addr, expected word, expected error}
  localparam logic [95:0] VEC [NVEC] = '{
    {16'd4,      16'd40,  16'h1234, 16'd40,  16'h1234, 16'd0},
    {16'd4,      16'd300, 16'hBEEF, 16'd44,  16'hBEEF, 16'd0},
    {16'd5,      16'd0,   16'h0077, 16'd255, 16'h0077, 16'd0},
    {16'd0,      16'd50,  16'd9,    16'd50,  16'd0,    16'd0},
    {16'd3,      16'd51,  16'd9,    16'd51,  16'd0,    16'd0},
    {16'd7,      16'd60,  16'd9,    16'd60,  16'd0,    16'd1},
    {16'hFFFF,   16'd61,  16'd9,    16'd0,   16'hFFFF, 16'd1},
    {16'd1,      16'd62,  16'd9,    16'd62,  16'd0,    16'd0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          dbg_en = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_re, mem_we;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          halted, error, dbg_valid;
  logic [DW-1:0] dbg_op, dbg_addr, dbg_val;

  logic [DW-1:0] mem [DEP];
  logic [AW-1:0] rd_log [64];
  int            rd_cnt = 0;
  int            dbg_cnt = 0;
  logic [DW-1:0] cap_op, cap_ad, cap_vl;
  int            n_chk = 0;
  int            n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stk3_core #(.DATA_W(DW), .DEPTH(DEP)) u_stk3_core (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .dbg_en_i    (dbg_en),
    .mem_addr_o  (mem_addr),
    .mem_re_o    (mem_re),
    .mem_we_o    (mem_we),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .halted_o    (halted),
    .error_o     (error),
    .dbg_valid_o (dbg_valid),
    .dbg_op_o    (dbg_op),
    .dbg_addr_o  (dbg_addr),
    .dbg_val_o   (dbg_val)
  );

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) begin
      mem_rdata <= mem[mem_addr];
      rd_log[rd_cnt[5:0]] <= mem_addr;
      rd_cnt <= rd_cnt + 1;
    end
    if (dbg_valid) begin
      dbg_cnt <= dbg_cnt + 1;
      cap_op <= dbg_op;
      cap_ad <= dbg_addr;
      cap_vl <= dbg_val;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [DW-1:0] op, input logic [DW-1:0] ad,
                     input logic [DW-1:0] vl);
    mem[a] = op; mem[a+1] = ad; mem[a+2] = vl;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0;
    for (int i = 0; i < DEP; i++) mem[i] = '0;
    @(negedge clk);
  endtask

  task automatic release_and_run();
    rst_n = 1'b1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 2000 && !halted; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int base;
    // R1 / R12: reset state and idle without start
    hold_reset();
    put(0, 16'd1, 16'd0, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 halted after reset", 32'(halted), 0);
    check("R1 error after reset", 32'(error), 0);
    check("R1 no access after reset", 32'({mem_re, mem_we}), 0);
    base = rd_cnt;
    repeat (6) @(negedge clk);
    check("R12 no reads without start", 32'(rd_cnt - base), 0);
    check("R12 not halted without start", 32'(halted), 0);

    // single-instruction vectors followed by HLT
    for (int v = 0; v < NVEC; v++) begin
      hold_reset();
      put(0, VEC[v][95:80], VEC[v][79:64], VEC[v][63:48]);
      put(3, 16'd1, 16'd0, 16'd0);
      release_and_run();
      check($sformatf("R4 vec%0d halted", v), 32'(halted), 1);
      check($sformatf("R10 vec%0d error", v), 32'(error), 32'(VEC[v][15:0]));
      check($sformatf("R5 R6 vec%0d mem word", v), 32'(mem[VEC[v][39:32]]), 32'(VEC[v][31:16]));
    end
    check("R9 no strobe with debug disabled", dbg_cnt, 0);

    // R2 / R3 / R8: fetch order and halt quiet
    hold_reset();
    put(0, 16'd4, 16'd40, 16'd7);
    put(3, 16'd0, 16'd0, 16'd0);
    put(6, 16'd1, 16'd0, 16'd0);
    base = rd_cnt;
    release_and_run();
    repeat (10) @(negedge clk);
    check("R8 reads stop at halt", 32'(rd_cnt - base), 9);
    for (int k = 0; k < 9; k++)
      check($sformatf("R2 R3 read %0d address", k), 32'(rd_log[6'(base + k)]), 32'(k));
    check("R5 LDI result", 32'(mem[40]), 7);
    check("R8 still halted", 32'(halted), 1);

    // R6 / R7: push and pop ordering
    hold_reset();
    put(0, 16'd5, 16'd0, 16'h0011);
    put(3, 16'd5, 16'd0, 16'h0022);
    put(6, 16'd6, 16'd100, 16'd0);
    put(9, 16'd6, 16'd101, 16'd0);
    put(12, 16'd1, 16'd0, 16'd0);
    release_and_run();
    check("R6 first push at top", 32'(mem[255]), 32'h11);
    check("R6 second push below", 32'(mem[254]), 32'h22);
    check("R7 first pop gets last push", 32'(mem[100]), 32'h22);
    check("R7 second pop gets first push", 32'(mem[101]), 32'h11);
    check("R7 no error", 32'(error), 0);

    // R11: RST restores SP, resumes at word 3; pop self-modifies word 9
    hold_reset();
    put(0, 16'd5, 16'd0, 16'd2);
    put(3, 16'd0, 16'd0, 16'd0);
    put(6, 16'd6, 16'd9, 16'd0);
    put(9, 16'd0, 16'd0, 16'h0033);
    put(12, 16'd1, 16'd0, 16'd0);
    release_and_run();
    check("R11 halted after rerun", 32'(halted), 1);
    check("R11 word 9 took pop of word 0", 32'(mem[9]), 5);
    check("R11 SP restored then wrapped", 32'(mem[0]), 32'h33);
    check("R11 no error", 32'(error), 0);

    // R9: debug strobe when enabled
    hold_reset();
    dbg_en = 1'b1;
    put(0, 16'd3, 16'h0021, 16'h4321);
    put(3, 16'd1, 16'd0, 16'd0);
    base = dbg_cnt;
    release_and_run();
    check("R9 one strobe", 32'(dbg_cnt - base), 1);
    check("R9 strobe opcode", 32'(cap_op), 3);
    check("R9 strobe address", 32'(cap_ad), 32'h21);
    check("R9 strobe value", 32'(cap_vl), 32'h4321);
    dbg_en = 1'b0;

    // R10: error stays and core stays quiet
    hold_reset();
    put(0, 16'd9, 16'd0, 16'd0);
    release_and_run();
    base = rd_cnt;
    repeat (8) @(negedge clk);
    check("R10 error sticky", 32'(error), 1);
    check("R10 halted with error", 32'(halted), 1);
    check("R10 no reads after error", 32'(rd_cnt - base), 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule